// File: doc/BRIEF.md
# Burst-four masked write memory

This block is a synchronous word memory with its own write path. A write command loads one base address, and the block then accepts four data beats that land in four consecutive words. Each beat carries active-low lane enables, sampled in the same cycle as the data. A lane whose enable is high keeps the contents it already had. The write data is split into fixed-width lanes. The default lane is a 9-bit byte. A parameter option selects 4-bit nibble lanes for narrow configurations.

A combinational read port returns the whole stored word at any address. It is meant for checking the result of each burst. A command that arrives while a burst is still running is dropped and reported on a one-cycle error flag. A synchronous reset stops any burst in progress but keeps the array contents.

Top module: `bfw_burst_mem`

## Requirements
- R1: A command cycle (wr_cmd high while idle) carries beat 0. The next three cycles carry beats 1, 2 and 3. Beat n is written to base + n, so each command moves four words.
- R2: The base address is the command address with its two low bits forced to zero. An unaligned command therefore writes the four words of its aligned group and nothing else.
- R3: Lane i covers wr_data bits [i*LANE_W +: LANE_W]. With wr_be_n[i] = 0 the lane is stored. With wr_be_n[i] = 1 the lane keeps its previous value in the target word.
- R4: The lane enables are sampled on every beat, and any combination may be used independently on each of the four beats.
- R5: busy is 1 in the three cycles that carry beats 1 to 3 and is 0 otherwise. A command is accepted in the cycle right after beat 3.
- R6: A command that arrives while busy is dropped. The dropped command's address group is not written, its beat still counts as the current burst's beat, and cmd_err is 1 for exactly the following cycle.
- R7: A synchronous reset clears busy and cmd_err, ends any running burst, and blocks writes while it is held. It leaves the array contents unchanged, and a new command is accepted once reset is released.
- R8: rd_data shows the full stored word at rd_addr without a clock delay.
- R9: With NIBBLE_MODE = 1 the lane width is 4 bits, so an 8-bit word has two nibble lanes that are masked independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_cmd | input | 1 | Write command strobe; loads the base address and carries beat 0 |
| wr_addr | input | ADDR_W | Write command address (two low bits ignored) |
| wr_data | input | DATA_W | Write data for the current beat |
| wr_be_n | input | DATA_W/LANE_W | Active-low lane enables for the current beat |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Stored word at rd_addr |
| busy | output | 1 | High while beats 1 to 3 of a burst are expected |
| cmd_err | output | 1 | One-cycle flag for a dropped overlapping command |

## Verification
The lane assertions assume the stored word at the write address is well defined before it is merged. The stimulus therefore fills every word it later touches with unmasked bursts before any masked burst runs. The sequencing assertions assume wr_cmd is a clean level that is sampled once per cycle. The bench drives all inputs on the falling edge, so each value is held across the rising edge that samples it. A dropped command is placed inside a filled region, so that the group it names can be shown to be unchanged.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
   localparam int BEATS  = 4;
   localparam int BEAT_W = 2;

   typedef enum logic {
      S_IDLE  = 1'b0,
      S_BURST = 1'b1
   } seq_state_e;

   // Lane width picked by the mask-granularity option.
   function automatic int lane_width(input bit nibble);
      return nibble ? 4 : 9;
   endfunction
endpackage

// File: rtl/bfw_seq.sv
module bfw_seq
   import bfw_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic              busy_o,
   output logic              err_o
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BEATS - 1);

   seq_state_e        state_q;
   logic [BEAT_W-1:0] beat_q;
   logic [ADDR_W-1:0] base_q;
   logic              err_q;
   logic              accept;
   logic [ADDR_W-1:0] aligned;

   assign aligned   = addr_i & ~ALIGN_MASK;
   assign accept    = !rst && (state_q == S_IDLE) && cmd_i;
   assign busy_o    = (state_q == S_BURST);
   assign err_o     = err_q;
   assign wr_en_o   = accept || (!rst && busy_o);
   assign wr_addr_o = accept ? aligned : (base_q | ADDR_W'(beat_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= S_IDLE;
         beat_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= busy_o && cmd_i;
         if (accept) begin
            base_q  <= aligned;
            beat_q  <= BEAT_W'(1);
            state_q <= S_BURST;
         end else if (busy_o) begin
            beat_q <= beat_q + BEAT_W'(1);
            if (beat_q == BEAT_W'(BEATS - 1)) state_q <= S_IDLE;
         end
      end
   end

   // R5: an idle command opens a burst whose next beat is number 1.
   p_accept_opens_r5: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && cmd_i) |=> (busy_o && beat_q == BEAT_W'(1)));
   // R1: the burst closes after its fourth beat.
   p_fourth_beat_closes_r1: assert property (@(posedge clk) disable iff (rst)
      (busy_o && beat_q == BEAT_W'(BEATS - 1)) |=> !busy_o);
   // R6: an overlapping command is flagged on the next cycle.
   p_overlap_flagged_r6: assert property (@(posedge clk) disable iff (rst)
      (busy_o && cmd_i) |=> err_o);
   // R6: the flag never rises without an overlap.
   p_no_spurious_err_r6: assert property (@(posedge clk) disable iff (rst)
      !(busy_o && cmd_i) |=> !err_o);
   // R7: reset leaves the sequencer idle and quiet.
   p_reset_idle_r7: assert property (@(posedge clk)
      rst |=> (!busy_o && !err_o));
endmodule

// File: rtl/bfw_merge.sv
module bfw_merge #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   localparam int W     = LANE_W * LANES
) (
   input  logic [W-1:0]     old_i,
   input  logic [W-1:0]     new_i,
   input  logic [LANES-1:0] keep_n_i,
   output logic [W-1:0]     word_o
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign word_o[i*LANE_W +: LANE_W] = keep_n_i[i] ? old_i[i*LANE_W +: LANE_W]
                                                      : new_i[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/bfw_array.sv
module bfw_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   localparam int DATA_W = LANE_W * LANES,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [LANES-1:0]  be_n_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] old_word;
   logic [DATA_W-1:0] merged;

   assign old_word = mem_q[waddr_i];
   assign rdata_o  = mem_q[raddr_i];

   bfw_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
      .old_i   (old_word),
      .new_i   (wdata_i),
      .keep_n_i(be_n_i),
      .word_o  (merged)
   );

   always_ff @(posedge clk) begin
      if (we_i) mem_q[waddr_i] <= merged;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      // R3: a disabled lane keeps its earlier contents.
      p_lane_kept_r3: assert property (@(posedge clk) disable iff (rst)
         (we_i && be_n_i[i]) |=>
            (mem_q[$past(waddr_i)][i*LANE_W +: LANE_W] == $past(old_word[i*LANE_W +: LANE_W])));
      // R3: an enabled lane takes the beat's data.
      p_lane_written_r3: assert property (@(posedge clk) disable iff (rst)
         (we_i && !be_n_i[i]) |=>
            (mem_q[$past(waddr_i)][i*LANE_W +: LANE_W] == $past(wdata_i[i*LANE_W +: LANE_W])));
   end
endmodule

// File: rtl/bfw_burst_mem.sv
module bfw_burst_mem
   import bfw_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 18,
   parameter bit NIBBLE_MODE = 1'b0,
   localparam int LANE_W     = lane_width(NIBBLE_MODE),
   localparam int LANES      = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_cmd,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_be_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              cmd_err
);
   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of lanes");
   end
   if (ADDR_W < BEAT_W) begin : g_bad_addr
      $error("ADDR_W must cover one burst group");
   end

   logic              we;
   logic [ADDR_W-1:0] waddr;

   bfw_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .cmd_i    (wr_cmd),
      .addr_i   (wr_addr),
      .wr_en_o  (we),
      .wr_addr_o(waddr),
      .busy_o   (busy),
      .err_o    (cmd_err)
   );

   bfw_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk    (clk),
      .rst    (rst),
      .we_i   (we),
      .waddr_i(waddr),
      .wdata_i(wr_data),
      .be_n_i (wr_be_n),
      .raddr_i(rd_addr),
      .rdata_o(rd_data)
   );

   // R2: the first write of a burst lands on an aligned word.
   p_aligned_start_r2: assert property (@(posedge clk) disable iff (rst)
      (!busy && wr_cmd) |-> (waddr[BEAT_W-1:0] == '0));
   // R7: no write goes to the array while reset is held.
   p_no_write_in_reset_r7: assert property (@(posedge clk)
      rst |-> !we);
endmodule

// File: tb/bfw_burst_mem_bench.sv
module bfw_burst_mem_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 18;
   localparam int LN = 2;
   localparam int LW = 9;

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] w;
      string         req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_cmd = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [LN-1:0] wr_be_n = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy, cmd_err;

   logic          n_cmd = 1'b0;
   logic [3:0]    n_addr = '0;
   logic [7:0]    n_data = '0;
   logic [1:0]    n_be_n = '0;
   logic [3:0]    n_rd_addr = '0;
   logic [7:0]    n_rd_data;
   logic          n_busy, n_err;

   int            n_vec = 0;
   int            n_bad = 0;
   exp_t          q[$];
   logic [DW-1:0] ref_mem [1 << AW];

   always #(CLK_PERIOD / 2) clk = ~clk;

   bfw_burst_mem #(.ADDR_W(AW), .DATA_W(DW), .NIBBLE_MODE(1'b0)) u_bfw_burst_mem (
      .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be_n(wr_be_n), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cmd_err(cmd_err)
   );

   bfw_burst_mem #(.ADDR_W(4), .DATA_W(8), .NIBBLE_MODE(1'b1)) u_bfw_burst_mem_nib (
      .clk(clk), .rst(rst), .wr_cmd(n_cmd), .wr_addr(n_addr), .wr_data(n_data),
      .wr_be_n(n_be_n), .rd_addr(n_rd_addr), .rd_data(n_rd_data), .busy(n_busy), .cmd_err(n_err)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   function automatic logic [DW-1:0] pat(input int s);
      return DW'(s * 32'h9E37 ^ 32'h2AB5);
   endfunction

   function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
      return a & ~AW'(3);
   endfunction

   // Reference merge: lane i is bits [i*LW +: LW], stored when its enable is 0.
   task automatic ref_apply(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] m);
      for (int i = 0; i < LN; i++)
         if (!m[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
   endtask

   // Called just after a falling edge; returns at the next falling edge.
   task automatic drive(input logic cmd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [LN-1:0] m);
      wr_cmd = cmd; wr_addr = a; wr_data = d; wr_be_n = m;
      @(negedge clk);
      wr_cmd = 1'b0;
   endtask

   task automatic push_group(input logic [AW-1:0] base, input string req);
      for (int n = 0; n < 4; n++) begin
         exp_t e;
         e.a = base + AW'(n); e.w = ref_mem[base + AW'(n)]; e.req = req;
         q.push_back(e);
      end
   endtask

   task automatic burst(input logic [AW-1:0] a, input logic [DW-1:0] d [4],
                        input logic [LN-1:0] m [4], input string req);
      wait (q.size() == 0);
      @(negedge clk);
      for (int n = 0; n < 4; n++) begin
         drive(n == 0, a, d[n], m[n]);
         ref_apply(align(a) + AW'(n), d[n], m[n]);
         if (n == 0) chk("R5 busy after command", 32'(busy), 32'd1);
         if (n == 3) chk("R5 busy after beat 3", 32'(busy), 32'd0);
      end
      push_group(align(a), req);
   endtask

   // Monitor: pops expected words and compares them through the read port (R8).
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            rd_addr = e.a;
            #1;
            chk(e.req, 32'(rd_data), 32'(e.w));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] d [4];
      logic [LN-1:0] m [4];
      repeat (3) @(negedge clk);
      chk("R7 busy in reset", 32'(busy), 32'd0);
      chk("R7 cmd_err in reset", 32'(cmd_err), 32'd0);
      rst = 1'b0;

      // R1/R8: fill words 0..31 with unmasked bursts.
      for (int b = 0; b < 8; b++) begin
         for (int n = 0; n < 4; n++) begin d[n] = pat(b * 4 + n); m[n] = 2'b00; end
         burst(AW'(b * 4), d, m, "R1 R8 fill word");
      end

      // R3/R4: a different lane pattern on each beat.
      d[0] = 18'h3_0A0A; d[1] = 18'h1_1B1B; d[2] = 18'h2_2C2C; d[3] = 18'h0_3D3D;
      m[0] = 2'b10; m[1] = 2'b01; m[2] = 2'b00; m[3] = 2'b01;
      burst(AW'(8), d, m, "R3 R4 per-beat lane mask");

      // R3: all lanes disabled leaves the group unchanged.
      for (int n = 0; n < 4; n++) begin d[n] = 18'h3_FFFF; m[n] = 2'b11; end
      burst(AW'(12), d, m, "R3 all lanes masked");

      // R2: unaligned command writes its aligned group; neighbour group untouched.
      for (int n = 0; n < 4; n++) begin d[n] = pat(100 + n); m[n] = 2'b00; end
      burst(AW'(22), d, m, "R2 unaligned base");
      push_group(AW'(24), "R2 neighbour group unchanged");

      // R5: a second command right after beat 3 is accepted.
      wait (q.size() == 0);
      @(negedge clk);
      for (int n = 0; n < 8; n++) begin
         logic [AW-1:0] a;
         a = (n < 4) ? AW'(28) : AW'(0);
         drive(n % 4 == 0, a, pat(200 + n), 2'b00);
         ref_apply(a + AW'(n % 4), pat(200 + n), 2'b00);
         if (n == 4) chk("R5 back-to-back command accepted", 32'(busy), 32'd1);
      end
      chk("R5 idle after second burst", 32'(busy), 32'd0);
      push_group(AW'(28), "R5 first of back-to-back");
      push_group(AW'(0), "R5 second of back-to-back");

      // R6: command during beat 1 is dropped and flagged for one cycle.
      wait (q.size() == 0);
      @(negedge clk);
      drive(1'b1, AW'(16), pat(300), 2'b00); ref_apply(AW'(16), pat(300), 2'b00);
      chk("R6 no flag on accepted command", 32'(cmd_err), 32'd0);
      drive(1'b1, AW'(24), pat(301), 2'b00); ref_apply(AW'(17), pat(301), 2'b00);
      chk("R6 cmd_err after overlap", 32'(cmd_err), 32'd1);
      drive(1'b0, AW'(24), pat(302), 2'b10); ref_apply(AW'(18), pat(302), 2'b10);
      chk("R6 cmd_err lasts one cycle", 32'(cmd_err), 32'd0);
      drive(1'b0, AW'(24), pat(303), 2'b00); ref_apply(AW'(19), pat(303), 2'b00);
      chk("R6 burst still ends on beat 3", 32'(busy), 32'd0);
      push_group(AW'(16), "R6 current burst keeps overlapped beat");
      push_group(AW'(24), "R6 dropped group unchanged");

      // R7: reset mid-burst stops it and keeps memory.
      wait (q.size() == 0);
      @(negedge clk);
      drive(1'b1, AW'(4), pat(400), 2'b00); ref_apply(AW'(4), pat(400), 2'b00);
      drive(1'b0, AW'(4), pat(401), 2'b00); ref_apply(AW'(5), pat(401), 2'b00);
      rst = 1'b1;
      drive(1'b0, AW'(4), pat(402), 2'b00);
      chk("R7 busy cleared by reset", 32'(busy), 32'd0);
      chk("R7 cmd_err cleared by reset", 32'(cmd_err), 32'd0);
      rst = 1'b0;
      push_group(AW'(4), "R7 memory kept across reset");
      for (int n = 0; n < 4; n++) begin d[n] = pat(500 + n); m[n] = 2'b01; end
      burst(AW'(4), d, m, "R7 command accepted after reset");

      // R9: nibble lanes on the 8-bit variant (lane 0 = bits 3:0, lane 1 = bits 7:4).
      wait (q.size() == 0);
      @(negedge clk);
      for (int n = 0; n < 8; n++) begin
         logic [7:0] dv [8];
         logic [1:0] mv [8];
         dv = '{8'h3C, 8'h5A, 8'hC3, 8'hF0, 8'hFF, 8'h00, 8'hAA, 8'h12};
         mv = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b11, 2'b00};
         n_cmd = (n % 4 == 0); n_addr = (n < 4) ? 4'd0 : 4'd1;
         n_data = dv[n]; n_be_n = mv[n];
         @(negedge clk);
         n_cmd = 1'b0;
      end
      n_rd_addr = 4'd0; #1 chk("R9 nibble lane 0 kept", 32'(n_rd_data), 32'hFC);
      n_rd_addr = 4'd1; #1 chk("R9 nibble lane 1 kept", 32'(n_rd_data), 32'h50);
      n_rd_addr = 4'd2; #1 chk("R9 nibble both kept", 32'(n_rd_data), 32'hC3);
      n_rd_addr = 4'd3; #1 chk("R9 nibble both written", 32'(n_rd_data), 32'h12);

      wait (q.size() == 0);
      @(negedge clk);
      summary();
      $finish;
   end
endmodule